// File: doc/BRIEF.md
# March Test Sequencer for Resistive Memory Arrays

This block is a built-in self-test sequencer for a word-addressed resistive memory array behind a synchronous single-port interface. When started, it walks a fixed six-element March algorithm over every word. It issues writes of all-zeros or all-ones words and reads that expect one of those two words, and it compares every returned word against the expected value. The sequence assumes that the forming step has already left every cell at 0. It contains a double read of 1 to expose cells that flip when read. It also contains back-to-back writes of 1 and then 0 to expose deep-state and slow-write cells. Ascending and descending address passes catch coupling between neighbours on both sides.

The array's read latency is a parameter. After issuing a read, the sequencer issues no other memory operation until the data is due, and then it compares. The first mismatch is recorded: element, operation within the element, address, expected word and returned word. The fail flag is raised. A configuration input selects whether the run stops at that point or continues to the end. A one-cycle done pulse closes every run.

Top module: `march_ctrl`

## Requirements
- R1: After reset, done, fail, mem_we and mem_re are 0, and all fault-record outputs are 0.
- R2: A start pulse while idle runs six elements in this order, with operations listed in issue order for each address. Element code 0: write 0. Code 1: read 0, write 1. Code 2: read 1, read 1, write 0. Code 3: read 0, write 1. Code 4: read 1, write 1, write 0. Code 5: read 0. Operation codes count from 0 within an element.
- R3: Elements with codes 0 to 3 visit addresses from 0 up to 2^ADDR_W-1. Elements with codes 4 and 5 visit addresses from 2^ADDR_W-1 down to 0.
- R4: At most one of mem_we and mem_re is high in any cycle, and both are low while idle. A write of 1 drives all-ones on mem_wdata and a write of 0 drives all-zeros.
- R5: A read issued in cycle t is compared against mem_rdata in cycle t+RD_LAT. No memory operation is issued in cycles t+1 to t+RD_LAT.
- R6: Each address costs one cycle per write and RD_LAT+1 cycles per read. A complete run therefore lasts 2^ADDR_W*(6*RD_LAT+12) cycles after the start edge. done is high for exactly one cycle, in the cycle after the final compare.
- R7: start is ignored while a run is in progress.
- R8: On the first mismatch of a run, fail rises and fail_elem, fail_op, fail_addr, fail_exp and fail_got take the element code, operation code, address, expected word and returned word. Later mismatches in the same run leave the record and fail unchanged. The next accepted start clears them.
- R9: With halt_on_fail high, a mismatch ends the run, and done pulses in the next cycle. With halt_on_fail low, the run continues to the full length of R6.
- R10: A fault-free array completes the run with fail low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (accepted only while idle) |
| halt_on_fail | input | 1 | 1: stop at the first mismatch; 0: run to the end |
| done | output | 1 | One-cycle pulse at the end of a run |
| fail | output | 1 | A mismatch has been seen in this run |
| fail_elem | output | 3 | Element code of the first mismatch |
| fail_op | output | 2 | Operation code within the element of the first mismatch |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_exp | output | DATA_W | Expected word of the first mismatch |
| fail_got | output | DATA_W | Returned word of the first mismatch |
| mem_addr | output | ADDR_W | Array address |
| mem_wdata | output | DATA_W | Array write data |
| mem_we | output | 1 | Array write enable |
| mem_re | output | 1 | Array read enable |
| mem_rdata | input | DATA_W | Array read data, valid RD_LAT cycles after mem_re |

## Verification
Assertions watch the following on every cycle:
- the port never carries a read and a write together;
- no operation is issued inside a read's latency window;
- the address steps by one in the selected direction and is never stepped past its end;
- elements advance one at a time;
- a halt is followed at once by done;
- done lasts a single cycle;
- the fault record stays frozen once fail is set.

Other behaviour shows only in the bench's scenarios. A behavioural array with injected stuck-at-1, stuck-at-0, read-disturb, slow-write-0 and deep-1 cells shows that each fault is first caught by the expected element and operation. Those scenarios also show the run length and halt timing, the first-mismatch rule with two faulty addresses, and that a start pulse in mid-run has no effect.

// File: rtl/march_pkg.sv
// Shared definitions for the March test sequencer: the operation encoding
// and the fixed six-element algorithm, held as functions of element code.
// Assumes element codes 0..5 and at most three operations per element.
package march_pkg;

    // Bit 1 marks a read; bit 0 is the data value written or expected.
    typedef enum logic [1:0] {
        OP_W0 = 2'd0,
        OP_W1 = 2'd1,
        OP_R0 = 2'd2,
        OP_R1 = 2'd3
    } march_op_e;

    localparam int NUM_ELEM = 6;
    localparam int ELEM_W   = 3;
    localparam int OPI_W    = 2;

    // Index of the final operation of an element.
    function automatic logic [OPI_W-1:0] elem_last_op(input logic [ELEM_W-1:0] e);
        case (e)
            3'd1, 3'd3: return 2'd1;
            3'd2, 3'd4: return 2'd2;
            default:    return 2'd0;
        endcase
    endfunction

    // Operation issued at position i of element e.
    function automatic march_op_e elem_op(input logic [ELEM_W-1:0] e,
                                          input logic [OPI_W-1:0] i);
        case (e)
            3'd0:       return OP_W0;
            3'd1, 3'd3: return (i == 2'd0) ? OP_R0 : OP_W1;
            3'd2:       return (i == 2'd2) ? OP_W0 : OP_R1;
            3'd4:       return (i == 2'd0) ? OP_R1 : ((i == 2'd1) ? OP_W1 : OP_W0);
            default:    return OP_R0;
        endcase
    endfunction

    // Address direction of an element: 1 means descending.
    function automatic logic elem_down(input logic [ELEM_W-1:0] e);
        return (e >= 3'd4);
    endfunction

endpackage

// File: rtl/march_addr_gen.sv
// Up/down address counter for the March sequencer. A load selects the
// direction and sets the counter to the first address in that direction;
// step moves one address onward. last flags the final address of a pass.
// Assumes the sequencer never steps while last is high.
module march_addr_gen #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_down,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    logic [ADDR_W-1:0] addr_q;
    logic              dir_q;

    // Counter and direction register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            dir_q  <= 1'b0;
        end else if (load) begin
            addr_q <= load_down ? TOP_ADDR : '0;
            dir_q  <= load_down;
        end else if (step) begin
            addr_q <= dir_q ? (addr_q - 1'b1) : (addr_q + 1'b1);
        end
    end

    // End-of-pass detect for the current direction.
    always_comb last = dir_q ? (addr_q == '0) : (addr_q == TOP_ADDR);

    assign addr = addr_q;

    p_step_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !dir_q) |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));
    p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && dir_q) |=> (addr_q == ADDR_W'($past(addr_q) - 1'b1)));
    p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !last);

endmodule

// File: rtl/march_seq.sv
// Operation sequencer: steps through elements, addresses and operations,
// issues one memory operation per issue cycle, and waits RD_LAT cycles
// after each read before enabling the compare. Ends the run after the last
// compare of the final element, or at once on a halting mismatch.
// Assumes RD_LAT >= 1 and that read data is valid RD_LAT cycles after issue.
module march_seq
    import march_pkg::*;
#(
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              halt_on_fail,
    input  logic              mismatch,
    input  logic              addr_last,
    output logic              run_start,
    output logic              addr_load,
    output logic              addr_load_down,
    output logic              addr_step,
    output logic [ELEM_W-1:0] elem,
    output logic [OPI_W-1:0]  opi,
    output march_op_e         cur_op,
    output logic              mem_we,
    output logic              mem_re,
    output logic              cmp_en,
    output logic              done
);
    localparam int WCW = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;

    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_state_e;

    seq_state_e       state;
    logic [WCW-1:0]   wcnt;
    logic             op_last, elem_last, halt, adv, finish;

    // Decode of the current position and of this cycle's progress.
    always_comb begin
        cur_op         = elem_op(elem, opi);
        op_last        = (opi == elem_last_op(elem));
        elem_last      = (elem == ELEM_W'(NUM_ELEM - 1));
        run_start      = (state == S_IDLE) && start;
        cmp_en         = (state == S_WAIT) && (wcnt == '0);
        halt           = cmp_en && mismatch && halt_on_fail;
        adv            = ((state == S_ISSUE) && !cur_op[1]) || (cmp_en && !halt);
        finish         = halt || (adv && op_last && addr_last && elem_last);
        addr_step      = adv && op_last && !addr_last;
        addr_load      = run_start || (adv && op_last && addr_last && !elem_last);
        addr_load_down = run_start ? elem_down('0) : elem_down(elem + 3'd1);
        mem_we         = (state == S_ISSUE) && !cur_op[1];
        mem_re         = (state == S_ISSUE) && cur_op[1];
    end

    // State, latency counter, position and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            wcnt  <= '0;
            elem  <= '0;
            opi   <= '0;
            done  <= 1'b0;
        end else begin
            done <= finish;
            if (finish)                  state <= S_IDLE;
            else if (run_start)          state <= S_ISSUE;
            else if (mem_re)             state <= S_WAIT;
            else if (adv)                state <= S_ISSUE;

            if (mem_re)                                wcnt <= WCW'(RD_LAT - 1);
            else if ((state == S_WAIT) && wcnt != '0)  wcnt <= wcnt - 1'b1;

            if (run_start) begin
                elem <= '0;
                opi  <= '0;
            end else if (adv && !finish) begin
                if (op_last) begin
                    opi <= '0;
                    if (addr_last) elem <= elem + 3'd1;
                end else begin
                    opi <= opi + 2'd1;
                end
            end
        end
    end

    p_one_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
    p_read_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (!mem_re && !mem_we));
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_halt_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (done && !mem_we && !mem_re));
    p_elem_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && op_last && addr_last && !elem_last) |=> (elem == ELEM_W'($past(elem) + 1'b1)));

endmodule

// File: rtl/march_resp.sv
// Response checker: compares the returned word with the all-zeros or
// all-ones expectation when the compare is enabled, and records the first
// mismatch of a run. The record and fail flag are cleared at run start.
module march_resp
    import march_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              cmp_en,
    input  logic              exp_ones,
    input  logic [DATA_W-1:0] rdata,
    input  logic [ELEM_W-1:0] elem,
    input  logic [OPI_W-1:0]  opi,
    input  logic [ADDR_W-1:0] addr,
    output logic              mismatch,
    output logic              fail,
    output logic [ELEM_W-1:0] cap_elem,
    output logic [OPI_W-1:0]  cap_op,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_exp,
    output logic [DATA_W-1:0] cap_got
);
    logic [DATA_W-1:0] exp_word;

    // Expected word and the mismatch flag.
    always_comb begin
        exp_word = {DATA_W{exp_ones}};
        mismatch = cmp_en && (rdata != exp_word);
    end

    // First-mismatch record.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            fail     <= 1'b0;
            cap_elem <= '0;
            cap_op   <= '0;
            cap_addr <= '0;
            cap_exp  <= '0;
            cap_got  <= '0;
        end else if (mismatch && !fail) begin
            fail     <= 1'b1;
            cap_elem <= elem;
            cap_op   <= opi;
            cap_addr <= addr;
            cap_exp  <= exp_word;
            cap_got  <= rdata;
        end
    end

    p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clear) |=> fail);
    p_record_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clear) |=> ($stable(cap_addr) && $stable(cap_elem) &&
                              $stable(cap_op) && $stable(cap_got)));
    p_record_real_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> (cap_exp != cap_got));

endmodule

// File: rtl/march_ctrl.sv
// Top of the March test sequencer. Connects the operation sequencer, the
// up/down address counter and the response checker to a synchronous
// single-port array with read latency RD_LAT (>= 1).
module march_ctrl
    import march_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              halt_on_fail,
    output logic              done,
    output logic              fail,
    output logic [2:0]        fail_elem,
    output logic [1:0]        fail_op,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_exp,
    output logic [DATA_W-1:0] fail_got,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic              run_start, addr_load, addr_load_down, addr_step, addr_last;
    logic              cmp_en, mismatch;
    logic [ELEM_W-1:0] elem;
    logic [OPI_W-1:0]  opi;
    march_op_e         cur_op;

    march_seq #(.RD_LAT(RD_LAT)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .halt_on_fail(halt_on_fail),
        .mismatch(mismatch), .addr_last(addr_last), .run_start(run_start),
        .addr_load(addr_load), .addr_load_down(addr_load_down),
        .addr_step(addr_step), .elem(elem), .opi(opi), .cur_op(cur_op),
        .mem_we(mem_we), .mem_re(mem_re), .cmp_en(cmp_en), .done(done)
    );

    march_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(addr_load), .load_down(addr_load_down),
        .step(addr_step), .addr(mem_addr), .last(addr_last)
    );

    march_resp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_resp (
        .clk(clk), .rst_n(rst_n), .clear(run_start), .cmp_en(cmp_en),
        .exp_ones(cur_op[0]), .rdata(mem_rdata), .elem(elem), .opi(opi),
        .addr(mem_addr), .mismatch(mismatch), .fail(fail), .cap_elem(fail_elem),
        .cap_op(fail_op), .cap_addr(fail_addr), .cap_exp(fail_exp),
        .cap_got(fail_got)
    );

    // Write data is the data bit of the current operation on every lane.
    always_comb mem_wdata = {DATA_W{cur_op[0]}};

endmodule

// File: tb/march_ctrl_bench.sv
`timescale 1ns/1ps
module march_ctrl_bench;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int RD_LAT = 2;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int FULL   = DEPTH * (6 * RD_LAT + 12);
    localparam int NCASE  = 9;

    // Fault modes of the behavioural array.
    localparam logic [2:0] FM_NONE = 3'd0, FM_SA1 = 3'd1, FM_SA0 = 3'd2,
                           FM_RDIS = 3'd3, FM_SW0 = 3'd4, FM_DP1 = 3'd5;

    typedef struct packed {
        logic [2:0]        mode;
        logic [ADDR_W-1:0] fa0;
        logic [ADDR_W-1:0] fa1;
        logic [2:0]        fbit;
        logic              halt;
        logic              xfail;
        logic [2:0]        xelem;
        logic [1:0]        xop;
        logic [ADDR_W-1:0] xaddr;
        logic [DATA_W-1:0] xexp;
        logic [DATA_W-1:0] xgot;
        logic [15:0]       xcyc;
    } tc_t;

    localparam tc_t CASES [NCASE] = '{
        '{FM_NONE, 4'd0,  4'd0,  3'd0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd0,  8'h00, 8'h00, 16'(FULL)},
        '{FM_SA1,  4'd3,  4'd9,  3'd2, 1'b0, 1'b1, 3'd1, 2'd0, 4'd3,  8'h00, 8'h04, 16'(FULL)},
        '{FM_SA0,  4'd7,  4'd7,  3'd0, 1'b0, 1'b1, 3'd2, 2'd0, 4'd7,  8'hFF, 8'hFE, 16'(FULL)},
        '{FM_RDIS, 4'd12, 4'd12, 3'd7, 1'b0, 1'b1, 3'd2, 2'd1, 4'd12, 8'hFF, 8'h7F, 16'(FULL)},
        '{FM_SW0,  4'd0,  4'd0,  3'd3, 1'b0, 1'b1, 3'd3, 2'd0, 4'd0,  8'h00, 8'h08, 16'(FULL)},
        '{FM_DP1,  4'd3,  4'd9,  3'd5, 1'b0, 1'b1, 3'd5, 2'd0, 4'd9,  8'h00, 8'h20, 16'(FULL)},
        '{FM_SA1,  4'd5,  4'd5,  3'd1, 1'b1, 1'b1, 3'd1, 2'd0, 4'd5,  8'h00, 8'h02,
          16'(DEPTH + 5 * (RD_LAT + 2) + RD_LAT + 1)},
        '{FM_SA1,  4'd15, 4'd15, 3'd0, 1'b0, 1'b1, 3'd1, 2'd0, 4'd15, 8'h00, 8'h01, 16'(FULL)},
        '{FM_DP1,  4'd0,  4'd0,  3'd6, 1'b1, 1'b1, 3'd5, 2'd0, 4'd0,  8'h00, 8'h40, 16'(FULL)}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic halt_on_fail = 1'b0;
    logic done, fail, mem_we, mem_re;
    logic [2:0] fail_elem;
    logic [1:0] fail_op;
    logic [ADDR_W-1:0] fail_addr, mem_addr;
    logic [DATA_W-1:0] fail_exp, fail_got, mem_wdata, mem_rdata;

    always #10 clk = ~clk;

    march_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_march_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .halt_on_fail(halt_on_fail),
        .done(done), .fail(fail), .fail_elem(fail_elem), .fail_op(fail_op),
        .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_got(fail_got),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    // Behavioural array with injectable faults on bit f_bit of f_a0/f_a1.
    logic [2:0]        f_mode = FM_NONE;
    logic [ADDR_W-1:0] f_a0 = '0, f_a1 = '0;
    logic [2:0]        f_bit = '0;
    logic              mem_clear = 1'b0;
    logic [DATA_W-1:0] arr [DEPTH];
    logic [DATA_W-1:0] pipe [RD_LAT];
    logic [1:0]        d1cnt [2];
    logic [DATA_W-1:0] wv, rv;
    logic              hit;
    int                ci;

    always @(posedge clk) begin
        if (mem_clear) begin
            for (int i = 0; i < DEPTH; i++) arr[i] <= '0;
            for (int i = 0; i < RD_LAT; i++) pipe[i] <= '0;
            d1cnt[0] <= '0;
            d1cnt[1] <= '0;
        end else begin
            hit = (mem_addr == f_a0) || (mem_addr == f_a1);
            ci  = (mem_addr == f_a1 && f_a1 != f_a0) ? 1 : 0;
            rv  = '0;
            if (mem_we) begin
                wv = mem_wdata;
                if (hit) begin
                    case (f_mode)
                        FM_SA1: wv[f_bit] = 1'b1;
                        FM_SA0: wv[f_bit] = 1'b0;
                        FM_SW0: if (arr[mem_addr][f_bit] && !mem_wdata[f_bit]) wv[f_bit] = 1'b1;
                        FM_DP1: begin
                            if (mem_wdata[f_bit]) begin
                                if (d1cnt[ci] != 2'd3) d1cnt[ci] <= d1cnt[ci] + 2'd1;
                            end else if (d1cnt[ci] >= 2'd2) begin
                                wv[f_bit] = 1'b1;
                            end else begin
                                d1cnt[ci] <= 2'd0;
                            end
                        end
                        default: ;
                    endcase
                end
                arr[mem_addr] <= wv;
            end
            if (mem_re) begin
                rv = arr[mem_addr];
                if (hit && f_mode == FM_SA1) rv[f_bit] = 1'b1;
                if (hit && f_mode == FM_SA0) rv[f_bit] = 1'b0;
                if (hit && f_mode == FM_RDIS && rv[f_bit])
                    arr[mem_addr] <= rv & ~(DATA_W'(1) << f_bit);
            end
            pipe[0] <= rv;
            for (int i = 1; i < RD_LAT; i++) pipe[i] <= pipe[i-1];
        end
    end
    assign mem_rdata = pipe[RD_LAT-1];

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One run: load faults, clear array, start, watch done and port idleness.
    task automatic run_one(input tc_t t, input int restart_at, input string nm);
        int  cyc;
        int  ndone;
        bit  quiet;
        f_mode = t.mode; f_a0 = t.fa0; f_a1 = t.fa1; f_bit = t.fbit;
        halt_on_fail = t.halt;
        mem_clear = 1'b1;
        @(negedge clk);
        mem_clear = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = -1; ndone = 0; quiet = 1'b1;
        for (int k = 0; k < 2000; k++) begin
            if (done) begin
                ndone++;
                if (cyc < 0) cyc = k;
            end
            if (cyc >= 0 && k > cyc && (mem_we || mem_re)) quiet = 1'b0;
            if (cyc >= 0 && k >= cyc + 4) break;
            start = (k == restart_at);
            @(negedge clk);
        end
        start = 1'b0;
        if (cyc < 0) begin
            n_chk++; n_err++;
            $display("FAIL R6 %s watchdog: actual=no done expected=done", nm);
        end
        chk($sformatf("R6 run length %s", nm), cyc, t.xcyc);
        chk($sformatf("R6 done pulses %s", nm), ndone, 1);
        chk($sformatf("R4 idle port after done %s", nm), quiet, 1);
        chk($sformatf("R10 fail flag %s", nm), fail, t.xfail);
        if (t.xfail) begin
            chk($sformatf("R2 element code %s", nm), fail_elem, t.xelem);
            chk($sformatf("R2 op code %s", nm), fail_op, t.xop);
            chk($sformatf("R3 address %s", nm), fail_addr, t.xaddr);
            chk($sformatf("R8 expected word %s", nm), fail_exp, t.xexp);
            chk($sformatf("R5 returned word %s", nm), fail_got, t.xgot);
        end
    endtask

    // Global watchdog.
    initial begin
        #(20 * 150000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state, with start held high during reset.
        start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", done, 0);
        chk("R1 fail after reset", fail, 0);
        chk("R1 mem_we after reset", mem_we, 0);
        chk("R1 mem_re after reset", mem_re, 0);
        chk("R1 record after reset", {fail_elem, fail_op, fail_addr, fail_exp, fail_got}, 0);

        // Table walk (R2, R3, R5, R6, R8, R9, R10).
        for (int i = 0; i < NCASE; i++) run_one(CASES[i], -1, $sformatf("case%0d", i));

        // R7: start pulse in mid-run must not restart the run.
        run_one(CASES[1], 100, "R7 mid-run start");

        // R8: a new run clears the record (fault-free run after a failing one).
        run_one(CASES[0], -1, "R8 clear on start");
        chk("R8 record cleared", {fail_addr, fail_got}, 0);

        // R4: write data follows the operation value.
        f_mode = FM_NONE;
        halt_on_fail = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R4 write 0 data in first element", {mem_we, mem_wdata}, {1'b1, 8'h00});

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule